// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block runs a 10-bit successive-approximation conversion. It drives the trial code of an external DAC and reads back one comparator decision bit per converter clock. It builds the result from the most significant bit down to the least. The converter clock comes from a free-running 7-bit divider on the system clock, and a 3-bit select picks the tap.

Software enables the block and sets the start bit. In single mode the start bit stays high until the result is ready. In free-running mode, once started, conversions run back to back. When a conversion ends, the block latches the result, sets a completion flag and, if the interrupt is enabled, raises an interrupt. The result is presented in a 16-bit word, aligned to either the low or the high end.

Top module: `sar_conv_seq`

## Requirements
- R1: The converter clock ticks once every D system clocks while enabled, where D = 2 for select 0 or 1 and D = 2^select otherwise. The divider counter is held at zero while disabled.
- R2: Except for the first conversion after enabling, a conversion spans exactly 13 converter clock ticks, counted from the edge that accepts the start.
- R3: The first conversion after the enable goes high spans 25 converter clock ticks.
- R4: During conversion the DAC code is set, one tick at a time, to a trial with the next lower bit set, from bit 9 to bit 0. A trial bit is kept when the comparator input is 1 and cleared when it is 0. The result is the resolved code: input 0 gives 0x000 and full scale gives 0x3FF.
- R5: A start pulse while enabled and idle sets the busy/start output on the next edge. Busy stays high for the whole conversion and in single mode falls on the completion edge. A start while busy or while disabled has no effect.
- R6: With free-run set, a new conversion begins on the completion edge with no idle cycle, whether the flag was cleared or not.
- R7: The flag is set on every completion edge and cleared by an acknowledge pulse or a flag-clear pulse. Setting wins over clearing in the same cycle.
- R8: The interrupt output is high exactly while the flag and the interrupt enable are both 1.
- R9: With justify = 0 the result sits in bits 9..0 of the 16-bit word. With justify = 1 it sits in bits 15..6. Unused bits read 0.
- R10: Dropping the enable aborts any conversion, clears busy within one cycle and resets the divider. The next conversion is again a 25-tick one.
- R11: The stored result changes only on a completion edge, so a partly resolved code is never visible at the result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| start_i | input | 1 | Start request pulse |
| free_run_i | input | 1 | Back-to-back conversion mode |
| irq_en_i | input | 1 | Interrupt enable |
| left_just_i | input | 1 | 1 = result in the upper bits |
| presc_sel_i | input | 3 | Divider tap select |
| flag_clr_i | input | 1 | Write-one-to-clear of the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| cmp_i | input | 1 | Comparator decision: input is at or above the trial level |
| dac_code_o | output | 10 | Trial code to the DAC |
| busy_o | output | 1 | Start bit readback, high while converting |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |
| result_o | output | 16 | Justified result word |

## Verification
The hardest case to reach is a completion edge that lands in the same cycle as a flag-clear, during free-running operation with the flag still set. There the set must win and the next conversion must begin without a gap. The bench holds the clear input high for a long stretch of free-running conversions. It also measures the spacing of successive result updates, so it can compare the interval against 13 divider periods. The phase of the free-running divider at start makes the first-conversion length uncertain by up to one divider period. So the bench checks that length against a window, and checks every later cycle against a behavioural model.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned RES_W     = 10;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned PRE_W     = 7;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NORM_LEN  = 13;
  localparam int unsigned FIRST_LEN = 25;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int unsigned PRE_W = sar_seq_pkg::PRE_W,
  parameter int unsigned SEL_W = sar_seq_pkg::SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  // mask = divisor - 1; select 0 and 1 both give /2
  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i == 0 || i < int'(sel_i)) mask[i] = 1'b1;
    end
  end

  assign tick_o = en_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + PRE_W'(1);
  end

  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_idle_cnt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int unsigned RES_W = sar_seq_pkg::RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             arm_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o
);
  logic [RES_W-1:0] sar_q;
  logic [RES_W-1:0] mask_q;
  logic [RES_W-1:0] kept;

  assign kept   = cmp_i ? sar_q : (sar_q & ~mask_q);
  assign code_o = sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (arm_i) begin
      sar_q  <= {1'b1, {(RES_W-1){1'b0}}};
      mask_q <= {1'b1, {(RES_W-1){1'b0}}};
    end else if (step_i) begin
      sar_q  <= kept | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end

  p_mask_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q));
  p_step_has_trial_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (mask_q != '0));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int unsigned RES_W     = sar_seq_pkg::RES_W,
  parameter int unsigned NORM_LEN  = sar_seq_pkg::NORM_LEN,
  parameter int unsigned FIRST_LEN = sar_seq_pkg::FIRST_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic free_run_i,
  input  logic tick_i,
  output logic busy_o,
  output logic clr_o,
  output logic arm_o,
  output logic step_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(FIRST_LEN + 1);

  logic             busy_q, first_q;
  logic [CNT_W-1:0] tcnt_q, tnext, len, off;
  logic             start_acc, tick_b;

  assign len       = first_q ? CNT_W'(FIRST_LEN) : CNT_W'(NORM_LEN);
  assign off       = len - CNT_W'(RES_W + 1);  // sample/settle ticks before MSB trial
  assign tnext     = tcnt_q + CNT_W'(1);
  assign start_acc = en_i & start_i & ~busy_q;
  assign tick_b    = busy_q & tick_i;

  assign arm_o  = tick_b & (tnext == off);
  assign step_o = tick_b & (tnext > off) & (tnext < len);
  assign done_o = tick_b & (tnext == len);
  assign clr_o  = ~en_i | start_acc;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      first_q <= 1'b1;
      tcnt_q  <= '0;
    end else if (!en_i) begin
      busy_q  <= 1'b0;
      first_q <= 1'b1;
      tcnt_q  <= '0;
    end else if (start_acc) begin
      busy_q  <= 1'b1;
      tcnt_q  <= '0;
    end else if (done_o) begin
      busy_q  <= free_run_i;
      first_q <= 1'b0;
      tcnt_q  <= '0;
    end else if (tick_b) begin
      tcnt_q  <= tnext;
    end
  end

  p_len_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (tcnt_q < len));
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_q && first_q));
  p_single_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !free_run_i) |=> !busy_q);
  p_back_to_back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && free_run_i) |=> (busy_q && tcnt_q == '0));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int unsigned RES_W     = sar_seq_pkg::RES_W,
  parameter int unsigned WORD_W    = sar_seq_pkg::WORD_W,
  parameter int unsigned PRE_W     = sar_seq_pkg::PRE_W,
  parameter int unsigned SEL_W     = sar_seq_pkg::SEL_W,
  parameter int unsigned NORM_LEN  = sar_seq_pkg::NORM_LEN,
  parameter int unsigned FIRST_LEN = sar_seq_pkg::FIRST_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              free_run_i,
  input  logic              irq_en_i,
  input  logic              left_just_i,
  input  logic [SEL_W-1:0]  presc_sel_i,
  input  logic              flag_clr_i,
  input  logic              irq_ack_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              busy_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic [WORD_W-1:0] result_o
);
  localparam int unsigned PAD_W = WORD_W - RES_W;

  logic             tick, clr, arm, step, done;
  logic [RES_W-1:0] code;
  logic [RES_W-1:0] res_q;
  logic             flag_q;

  sar_clk_div #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_div (
    .clk_i, .rst_ni, .en_i, .sel_i(presc_sel_i), .tick_o(tick)
  );

  sar_seq_ctrl #(.RES_W(RES_W), .NORM_LEN(NORM_LEN), .FIRST_LEN(FIRST_LEN)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .start_i, .free_run_i, .tick_i(tick),
    .busy_o, .clr_o(clr), .arm_o(arm), .step_o(step), .done_o(done)
  );

  sar_bit_engine #(.RES_W(RES_W)) u_sar (
    .clk_i, .rst_ni, .clr_i(clr), .arm_i(arm), .step_i(step), .cmp_i, .code_o(code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (done) res_q <= code;
      if (done)                         flag_q <= 1'b1;
      else if (flag_clr_i || irq_ack_i) flag_q <= 1'b0;
    end
  end

  assign dac_code_o = code;
  assign flag_o     = flag_q;
  assign irq_o      = flag_q & irq_en_i;
  assign result_o   = left_just_i ? {res_q, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, res_q};

  p_flag_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(done));
  p_res_atomic_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_q) |-> $past(done));
  p_done_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> flag_q);
endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 0, start = 0, free_run = 0, irq_en = 0, left_just = 0;
  logic [2:0]  sel = 0;
  logic        flag_clr = 0, irq_ack = 0;
  logic        cmp;
  logic [9:0]  dac_code;
  logic        busy, flag, irq;
  logic [15:0] result;
  int          vin = 0;

  int checks = 0, errors = 0, cyc = 0;

  // model state
  int m_pc = 0, m_tcnt = 0, m_sar = 0, m_mask = 0, m_res = 0;
  bit m_busy = 0, m_first = 1, m_flag = 0;

  assign cmp = (vin >= int'(dac_code));

  sar_conv_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .free_run_i(free_run),
    .irq_en_i(irq_en), .left_just_i(left_just), .presc_sel_i(sel),
    .flag_clr_i(flag_clr), .irq_ack_i(irq_ack), .cmp_i(cmp),
    .dac_code_o(dac_code), .busy_o(busy), .flag_o(flag), .irq_o(irq), .result_o(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference, updated on each edge, compared shortly after
  always @(posedge clk) begin
    int div, len, off, t;
    bit tick, cmpv, done;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      finish_sim();
    end
    done = 0;
    if (rst_n) begin
      div  = (sel <= 1) ? 2 : (1 << sel);
      tick = en && ((m_pc % div) == div - 1);
      len  = m_first ? 25 : 13;
      off  = len - 11;
      cmpv = (vin >= m_sar);
      if (!en) begin
        m_busy = 0; m_tcnt = 0; m_first = 1; m_sar = 0; m_mask = 0;
      end else if (start && !m_busy) begin
        m_busy = 1; m_tcnt = 0; m_sar = 0; m_mask = 0;
      end else if (m_busy && tick) begin
        t = m_tcnt + 1;
        if (t == off) begin
          m_sar = 512; m_mask = 512;
        end else if (t > off && t < len) begin
          if (!cmpv) m_sar -= m_mask;
          m_mask /= 2;
          m_sar += m_mask;
        end
        if (t == len) begin
          m_res = m_sar; done = 1; m_tcnt = 0; m_busy = free_run; m_first = 0;
        end else m_tcnt = t;
      end
      if (done) m_flag = 1;
      else if (flag_clr || irq_ack) m_flag = 0;
      m_pc = en ? (m_pc + 1) % 128 : 0;
      #1;
      chk(busy === m_busy, "R5 busy", busy, m_busy);
      chk(dac_code === 10'(m_sar), "R4 dac code", dac_code, m_sar);
      chk(flag === m_flag, "R7 flag", flag, m_flag);
      chk(irq === (m_flag && irq_en), "R8 irq", irq, m_flag && irq_en);
      chk(result === (left_just ? 16'(m_res << 6) : 16'(m_res)), "R9 result",
          result, left_just ? (m_res << 6) : m_res);
    end
  end

  task automatic conv(output int n);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (busy === 1'b1 && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic wait_res_change(output int at);
    logic [15:0] prev;
    int k;
    prev = result; k = 0;
    while (result === prev && k < 6000) begin @(negedge clk); k++; end
    at = cyc;
  endtask

  initial begin
    int n, t0, t1, t2;
    logic [15:0] r_mid;
    #(CLK_PERIOD*2 + 3);
    // reset state
    chk(busy === 0 && flag === 0 && irq === 0, "R5 reset outputs", {busy, flag, irq}, 0);
    chk(result === 0 && dac_code === 0, "R11 reset result", result, 0);
    @(negedge clk); rst_n = 1;

    // start while disabled ignored
    pulse(start);
    @(negedge clk);
    chk(busy === 0, "R5 start while disabled", busy, 0);

    // first conversion, /2
    en = 1; sel = 0; vin = 'h2A5;
    conv(n);
    chk(n >= 24*2+1 && n <= 25*2, "R3 first conversion length /2", n, 50);
    chk(result === 16'h02A5, "R4 resolved code", result, 'h2A5);
    chk(flag === 1 && irq === 0, "R8 irq masked", irq, 0);
    @(negedge clk); irq_en = 1; #1;
    chk(irq === 1, "R8 irq when enabled", irq, 1);
    pulse(irq_ack); #1;
    chk(flag === 0 && irq === 0, "R7 ack clears flag", flag, 0);

    // normal conversion, /8, full scale
    sel = 3; vin = 1023;
    conv(n);
    chk(n >= 12*8+1 && n <= 13*8, "R2 normal length /8", n, 104);
    chk(result === 16'h03FF, "R4 full scale", result, 'h3FF);
    @(negedge clk); left_just = 1; #1;
    chk(result === 16'hFFC0, "R9 left justified", result, 'hFFC0);
    pulse(flag_clr); #1;
    chk(flag === 0, "R7 write-one clears flag", flag, 0);

    // zero input; result must hold old value mid-conversion
    vin = 0; left_just = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    r_mid = result;
    chk(r_mid === 16'h03FF, "R11 result held during conversion", r_mid, 'h3FF);
    pulse(start); // ignored while busy
    while (busy === 1'b1) @(negedge clk);
    chk(result === 0, "R4 zero input", result, 0);

    // free run /2 with select 1, flag never cleared
    sel = 1; free_run = 1; vin = 100;
    pulse(start);
    wait_res_change(t0); vin = 900;
    wait_res_change(t1); vin = 333;
    wait_res_change(t2);
    chk(t2 - t1 == 26, "R6 back-to-back spacing /2 (R1)", t2 - t1, 26);
    chk(busy === 1 && flag === 1, "R6 runs with flag set", busy, 1);
    // /32 spacing, clear held high across completions
    sel = 5; flag_clr = 1; vin = 700;
    wait_res_change(t0); vin = 50;
    wait_res_change(t1); vin = 600;
    #1;
    chk(flag === 1, "R7 set wins over clear", flag, 1);
    wait_res_change(t2);
    chk(t2 - t1 == 13*32, "R1 divider /32 spacing", t2 - t1, 416);
    flag_clr = 0;

    // abort mid conversion
    repeat (30) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(busy === 0, "R10 abort clears busy", busy, 0);
    free_run = 0; en = 1; sel = 7; vin = 512;
    conv(n);
    chk(n >= 24*128+1 && n <= 25*128, "R10 first length after re-enable (R3)", n, 3200);
    chk(result === 16'h0200, "R4 mid scale", result, 'h200);

    repeat (3) @(negedge clk);
    finish_sim();
  end
endmodule